// File: doc/BRIEF.md
# Half-Bridge PWM Generator with Pulse-Width Matching

This block produces the two alternating gate drives of a half-bridge power stage from a digital ramp counter. Each ramp period is one half of the switching period; the periods alternate between a low-side phase and a high-side phase, so each gate switches at half the ramp rate. In normal operation the voltage loop's duty command sets the width of both pulses. The ramp period, the duty command and the blanking length are captured at the start of every half period. A change on those inputs therefore never disturbs a pulse already in progress.

A comparator input reports when the sensed low-side current exceeds its limit. For a programmable number of counts after the low-side gate turns on, that input is ignored, so turn-on noise cannot trip it. If it trips while unblanked, the low-side pulse ends and a limit flag rises. The block stores the width the low pulse reached. The following high-side pulse is then ended at that same width whatever the comparator does, which keeps the transformer's volt-seconds balanced. While the flag is high, an accumulate enable lets external hiccup circuitry integrate the time spent in limit.

Top module: `hb_match_pwm`

## Requirements
- R1: The ramp counts 0 up to the loaded period value inclusive, so each half period lasts period+1 clock cycles. After reset the first half period is a low-side phase, and the phases then alternate.
- R2: The period, duty and blanking inputs are sampled only on the cycle a half period starts (ramp 0). Changes at other times take effect at the next half period.
- R3: With no limit event, each gate is high in its own phase for the cycles where the ramp is below the loaded duty value. That gives a width of duty cycles, capped at the phase length.
- R4: While the low-side phase's ramp is below the loaded blanking value, the comparator input has no effect: the low pulse keeps its width and the flag stays low.
- R5: A comparator trip sampled during the low pulse at ramp k ≥ blanking takes the low gate low on the next cycle. The low pulse is then k+1 cycles wide, and the flag is high from that next cycle.
- R6: After a trip, the next high-side pulse is min(k+1, loaded duty) cycles wide, whatever the comparator input does during it.
- R7: The flag clears on the first cycle of the next low-side phase. The stored width stops applying after the matched high pulse, so later high pulses return to the duty width.
- R8: The accumulate-enable output is high exactly when the limit flag is high.
- R9: Both gates are low during reset, and the two gates are never high in the same cycle.
- R10: A comparator trip during the high-side phase, or during the low-side phase after the low pulse has ended, has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| period_in | input | CNT_W | Last ramp count of a half period |
| duty_in | input | CNT_W | Pulse width command in cycles |
| blank_in | input | CNT_W | Blanking length in cycles after low-side turn-on |
| ilim_trip | input | 1 | Current-limit comparator output |
| gate_lo | output | 1 | Low-side gate drive |
| gate_hi | output | 1 | High-side gate drive |
| limit_flag | output | 1 | Cycle-by-cycle limit active |
| hiccup_acc_en | output | 1 | Enable for external hiccup integration |

## Verification
The hardest situation to reach is a mismatch between the captured width and a duty command loaded between the tripped low pulse and the matched high pulse. The stimulus trips the comparator late in a low pulse and, in the same phase, lowers the duty input, so the high phase loads a smaller duty than the held width and the precedence rule decides. Other sequences hold the comparator high across the whole matched high phase, only inside the blanking window, and in the tail of a low phase after the pulse has ended. Each of these is timed against the bench's own ramp model.

// File: rtl/hbm_pkg.sv
package hbm_pkg;

  typedef enum logic {
    PH_LO = 1'b0,
    PH_HI = 1'b1
  } phase_e;

  // Width of a low pulse cut at ramp count r: counts 0..r were driven.
  function automatic int unsigned cut_width(input int unsigned r);
    return r + 1;
  endfunction

  // Width applied to a high pulse: the stored width wins when smaller.
  function automatic int unsigned hi_limit(input logic vld,
                                           input int unsigned held,
                                           input int unsigned duty);
    if (vld && (held < duty)) return held;
    return duty;
  endfunction

  // Comparator sampling window opens once the blanking count is reached.
  function automatic logic past_blank(input int unsigned r,
                                      input int unsigned blank);
    return r >= blank;
  endfunction

endpackage

// File: rtl/hbm_ramp.sv
module hbm_ramp
  import hbm_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] period_in,
  input  logic [CNT_W-1:0] duty_in,
  input  logic [CNT_W-1:0] blank_in,
  output logic [CNT_W-1:0] ramp,
  output phase_e           phase,
  output logic [CNT_W-1:0] duty_q,
  output logic [CNT_W-1:0] blank_q,
  output logic             wrap
);

  logic [CNT_W-1:0] per_q;

  assign wrap = (ramp == per_q);

  // Reset parks the ramp at the end of a high phase with a zero period,
  // so the first clock opens a low phase and loads the configuration.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ramp    <= '0;
      phase   <= PH_HI;
      per_q   <= '0;
      duty_q  <= '0;
      blank_q <= '0;
    end else if (wrap) begin
      ramp    <= '0;
      phase   <= (phase == PH_LO) ? PH_HI : PH_LO;
      per_q   <= period_in;
      duty_q  <= duty_in;
      blank_q <= blank_in;
    end else begin
      ramp    <= ramp + 1'b1;
    end
  end

endmodule

// File: rtl/hbm_limit.sv
module hbm_limit
  import hbm_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ilim_trip,
  input  logic             gate_lo,
  input  logic [CNT_W-1:0] ramp,
  input  logic [CNT_W-1:0] blank_q,
  input  phase_e           phase,
  input  logic             wrap,
  output logic             trip_ok,
  output logic             flag,
  output logic [CNT_W-1:0] hold_val,
  output logic             hold_vld
);

  logic hi_end;

  assign trip_ok = ilim_trip && gate_lo && (phase == PH_LO)
                   && past_blank(int'(ramp), int'(blank_q));
  assign hi_end  = wrap && (phase == PH_HI);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag     <= 1'b0;
      hold_val <= '0;
      hold_vld <= 1'b0;
    end else if (trip_ok) begin
      flag     <= 1'b1;
      hold_val <= CNT_W'(cut_width(int'(ramp)));
      hold_vld <= 1'b1;
    end else if (hi_end) begin
      flag     <= 1'b0;
      hold_vld <= 1'b0;
    end
  end

endmodule

// File: rtl/hbm_gate.sv
module hbm_gate
  import hbm_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  phase_e           phase,
  input  logic [CNT_W-1:0] ramp,
  input  logic [CNT_W-1:0] duty_q,
  input  logic             flag,
  input  logic             hold_vld,
  input  logic [CNT_W-1:0] hold_val,
  output logic             gate_lo,
  output logic             gate_hi
);

  logic [CNT_W-1:0] hi_stop;

  assign hi_stop = CNT_W'(hi_limit(hold_vld, int'(hold_val), int'(duty_q)));
  assign gate_lo = (phase == PH_LO) && (ramp < duty_q) && !flag;
  assign gate_hi = (phase == PH_HI) && (ramp < hi_stop);

endmodule

// File: rtl/hb_match_pwm.sv
module hb_match_pwm
  import hbm_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] period_in,
  input  logic [CNT_W-1:0] duty_in,
  input  logic [CNT_W-1:0] blank_in,
  input  logic             ilim_trip,
  output logic             gate_lo,
  output logic             gate_hi,
  output logic             limit_flag,
  output logic             hiccup_acc_en
);

  logic [CNT_W-1:0] ramp;
  phase_e           phase;
  logic [CNT_W-1:0] duty_q;
  logic [CNT_W-1:0] blank_q;
  logic             wrap;
  logic             trip_ok;
  logic [CNT_W-1:0] hold_val;
  logic             hold_vld;

  hbm_ramp #(.CNT_W(CNT_W)) u_ramp (
    .clk(clk), .rst_n(rst_n),
    .period_in(period_in), .duty_in(duty_in), .blank_in(blank_in),
    .ramp(ramp), .phase(phase), .duty_q(duty_q), .blank_q(blank_q),
    .wrap(wrap)
  );

  hbm_limit #(.CNT_W(CNT_W)) u_limit (
    .clk(clk), .rst_n(rst_n), .ilim_trip(ilim_trip), .gate_lo(gate_lo),
    .ramp(ramp), .blank_q(blank_q), .phase(phase), .wrap(wrap),
    .trip_ok(trip_ok), .flag(limit_flag),
    .hold_val(hold_val), .hold_vld(hold_vld)
  );

  hbm_gate #(.CNT_W(CNT_W)) u_gate (
    .phase(phase), .ramp(ramp), .duty_q(duty_q), .flag(limit_flag),
    .hold_vld(hold_vld), .hold_val(hold_val),
    .gate_lo(gate_lo), .gate_hi(gate_hi)
  );

  assign hiccup_acc_en = limit_flag;

endmodule

// File: rtl/hbm_checker.sv
module hbm_checker
  import hbm_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             gate_lo,
  input logic             gate_hi,
  input logic             limit_flag,
  input logic             hiccup_acc_en,
  input logic [CNT_W-1:0] ramp,
  input phase_e           phase,
  input logic [CNT_W-1:0] duty_q,
  input logic [CNT_W-1:0] blank_q,
  input logic             trip_ok,
  input logic [CNT_W-1:0] hold_val,
  input logic             hold_vld
);

  assert_no_overlap_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(gate_lo && gate_hi));

  assert_cfg_held_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (ramp != '0) |-> ($stable(duty_q) && $stable(blank_q)));

  assert_blank_respected_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(limit_flag) |-> ($past(phase) == PH_LO && $past(ramp) >= $past(blank_q)));

  assert_lo_cut_R5: assert property (@(posedge clk) disable iff (!rst_n)
    trip_ok |=> !gate_lo);

  assert_hi_matched_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_vld && gate_hi) |-> (ramp < hold_val));

  assert_flag_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(limit_flag) |-> (phase == PH_LO && ramp == '0));

  assert_hold_dropped_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_LO && ramp == '0) |-> !hold_vld);

  assert_acc_rise_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hiccup_acc_en) |-> $past(trip_ok));

endmodule

bind hb_match_pwm hbm_checker #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .gate_lo(gate_lo), .gate_hi(gate_hi),
  .limit_flag(limit_flag), .hiccup_acc_en(hiccup_acc_en),
  .ramp(ramp), .phase(phase), .duty_q(duty_q), .blank_q(blank_q),
  .trip_ok(trip_ok), .hold_val(hold_val), .hold_vld(hold_vld)
);

// File: tb/hb_match_pwm_bench.sv
`timescale 1ns/1ps
module hb_match_pwm_bench;
  localparam int W = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [W-1:0] period_in = 8'd19;
  logic [W-1:0] duty_in   = 8'd12;
  logic [W-1:0] blank_in  = 8'd4;
  logic ilim_trip = 1'b0;
  logic gate_lo, gate_hi, limit_flag, hiccup_acc_en;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  hb_match_pwm #(.CNT_W(W)) u_hb_match_pwm (
    .clk(clk), .rst_n(rst_n), .period_in(period_in), .duty_in(duty_in),
    .blank_in(blank_in), .ilim_trip(ilim_trip), .gate_lo(gate_lo),
    .gate_hi(gate_hi), .limit_flag(limit_flag), .hiccup_acc_en(hiccup_acc_en)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // Behavioural reference: half periods alternate, low phase first.
  int m_ramp, m_per, m_duty, m_blank, m_held;
  bit m_hi, m_flag, m_held_ok;
  int cyc = 0;

  function automatic bit exp_lo();
    return !m_hi && (m_ramp < m_duty) && !m_flag;
  endfunction
  function automatic bit exp_hi();
    int lim;
    lim = m_duty;
    if (m_held_ok && m_held < lim) lim = m_held;
    return m_hi && (m_ramp < lim);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ramp = 0; m_per = -1; m_hi = 1; m_duty = 0; m_blank = 0;
      m_flag = 0; m_held_ok = 0; m_held = 0;
    end else begin
      cyc++;
      if (exp_lo() && m_ramp >= m_blank && ilim_trip) begin
        m_flag = 1; m_held_ok = 1; m_held = m_ramp + 1;
      end
      if (m_per < 0 || m_ramp == m_per) begin
        if (m_hi) begin m_flag = 0; m_held_ok = 0; end
        m_hi = !m_hi; m_ramp = 0;
        m_per = period_in; m_duty = duty_in; m_blank = blank_in;
      end else begin
        m_ramp++;
      end
    end
  end

  // Per-cycle comparison and pulse-width monitor.
  int lo_cnt = 0, hi_cnt = 0, lo_w = 0, hi_w = 0, lo_done = 0, hi_done = 0;
  int lo_rise = 0, lo_per = 0;
  always @(negedge clk) begin
    if (rst_n && !done) begin
      check(gate_lo == exp_lo(), "R3 low gate", gate_lo, exp_lo());
      check(gate_hi == exp_hi(), "R6 high gate", gate_hi, exp_hi());
      check(limit_flag == m_flag, "R5 flag", limit_flag, m_flag);
      check(hiccup_acc_en == limit_flag, "R8 accumulate", hiccup_acc_en, limit_flag);
      check(!(gate_lo && gate_hi), "R9 overlap", 1, 0);
      if (gate_lo) begin
        if (lo_cnt == 0) begin lo_per = cyc - lo_rise; lo_rise = cyc; end
        lo_cnt++;
      end else if (lo_cnt > 0) begin
        lo_w = lo_cnt; lo_cnt = 0; lo_done++;
      end
      if (gate_hi) hi_cnt++;
      else if (hi_cnt > 0) begin hi_w = hi_cnt; hi_cnt = 0; hi_done++; end
    end
  end

  task automatic wait_at(input bit hi, input int r);
    do @(negedge clk); while (!(m_hi == hi && m_ramp == r));
  endtask
  task automatic wait_lo();
    int n = lo_done;
    while (lo_done == n) @(negedge clk);
  endtask
  task automatic wait_hi();
    int n = hi_done;
    while (hi_done == n) @(negedge clk);
  endtask

  initial begin
    int t0;
    repeat (3) @(negedge clk);
    check(!gate_lo && !gate_hi, "R9 reset gates", {gate_lo, gate_hi}, 0);
    rst_n = 1'b1;

    // Plain pulses and phase length
    wait_lo(); wait_lo();
    check(lo_w == 12, "R3 low width", lo_w, 12);
    wait_hi();
    check(hi_w == 12, "R3 high width", hi_w, 12);
    wait_lo();
    check(lo_per == 40, "R1 switching period", lo_per, 40);

    // Trip only inside blanking window
    wait_at(0, 0); ilim_trip = 1;
    wait_at(0, 4); ilim_trip = 0;
    check(limit_flag == 0, "R4 blank flag", limit_flag, 0);
    wait_lo();
    check(lo_w == 12, "R4 blank width", lo_w, 12);

    // Trip at ramp 6, held high through the matched high pulse
    wait_at(0, 6); ilim_trip = 1;
    @(negedge clk);
    check(limit_flag == 1, "R5 flag rise", limit_flag, 1);
    check(hiccup_acc_en == 1, "R8 accumulate on", hiccup_acc_en, 1);
    wait_lo();
    check(lo_w == 7, "R5 cut width", lo_w, 7);
    wait_hi();
    check(hi_w == 7, "R6 matched width", hi_w, 7);
    wait_at(1, 15); ilim_trip = 0;
    wait_at(0, 1);
    check(limit_flag == 0, "R7 flag clear", limit_flag, 0);
    wait_hi();
    check(hi_w == 12, "R7 width restored", hi_w, 12);

    // Trips with no effect
    wait_at(1, 2); ilim_trip = 1;
    wait_at(1, 10); ilim_trip = 0;
    check(limit_flag == 0, "R10 high-phase trip", limit_flag, 0);
    wait_at(0, 14); ilim_trip = 1;
    wait_at(0, 18); ilim_trip = 0;
    @(negedge clk);
    check(limit_flag == 0, "R10 late trip", limit_flag, 0);

    // Configuration change mid-phase
    wait_at(0, 2); duty_in = 8'd5; period_in = 8'd9;
    wait_lo();
    check(lo_w == 12, "R2 low width kept", lo_w, 12);
    wait_hi();
    check(hi_w == 5, "R2 new duty", hi_w, 5);
    wait_at(1, 0); t0 = cyc;
    wait_at(0, 0);
    check(cyc - t0 == 10, "R1 reloaded phase length", cyc - t0, 10);

    // Duty lowered below the held width
    duty_in = 8'd12; period_in = 8'd19;
    wait_at(1, 0); wait_at(0, 0);
    wait_at(0, 9); ilim_trip = 1; duty_in = 8'd5;
    wait_at(0, 10); ilim_trip = 0;
    wait_lo();
    check(lo_w == 10, "R5 cut width late", lo_w, 10);
    wait_hi();
    check(hi_w == 5, "R6 duty precedence", hi_w, 5);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(200000 * 20);
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule